// File: doc/BRIEF.md
# Serial Flash Write Protection Controller

This block guards program and erase traffic for a 16 MiB serial NOR flash. It holds the write-enable latch, a five-bit protect code, two status-lock bits and the deep-power-down state. Each cycle it decides whether the command pulse presented to it may go ahead. A command decoder upstream delivers already-decoded one-cycle pulses, the 24-bit target address and the new status bits. The sequencer downstream starts the internal operation only when `grant_o` is high in the same cycle as the request.

The protect code shields a power-of-two share of the array, from 1/64 up to 1/2, at either the top or the bottom of the address space. Its low three bits give the size, and bit 3 chooses between top and bottom. The smallest share is four 64 KiB blocks. A low level on the write-protect pin freezes the status bits. While the part is in deep power-down it ignores every command except the release.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `wel_o`, `prot_o`, `lock_o` and `dpd_o` are all 0, and `grant_o` stays 0 while no command pulse is present.
- R2: When not in deep power-down, a write-enable pulse makes `wel_o` 1 from the next cycle, and a write-disable pulse makes it 0 from the next cycle.
- R3: Every granted page program, sector erase, block erase, chip erase, security-register program or erase, and status write clears `wel_o` from the next cycle.
- R4: Codes 00001 to 00110 protect the top 4, 8, 16, 32, 64 or 128 blocks of 64 KiB. For example, 00001 covers FC0000h to FFFFFFh. Any code whose bits [2:0] are 000 and whose bit 4 is 0 protects nothing.
- R5: Codes 01001 to 01110 protect the bottom 4 to 128 blocks. For example, 01110 covers 000000h to 7FFFFFh.
- R6: Any code with bits [2:0] = 111, or with bit 4 = 1, protects the whole array.
- R7: A page program, sector erase or block erase is granted in its own cycle only when `wel_o` is 1, `dpd_o` is 0, and the block `addr_i[23:16]` is not protected.
- R8: A chip erase is granted only when `wel_o` is 1, `dpd_o` is 0 and the current code protects nothing.
- R9: A security-register program or erase is granted whenever `wel_o` is 1 and `dpd_o` is 0, whatever the protect code.
- R10: A status write is granted when `wel_o` is 1, `dpd_o` is 0 and `wp_ni` is 1. It then loads `sr_new_i[4:0]` into `prot_o` and `sr_new_i[6:5]` into `lock_o` at that clock edge. While `wp_ni` is 0, `prot_o` and `lock_o` do not change.
- R11: Outside deep power-down, an enter pulse sets `dpd_o` from the next cycle. While `dpd_o` is 1, every pulse except release is ignored and `grant_o` stays 0. A release pulse clears `dpd_o`.
- R12: A refused request leaves `wel_o`, `prot_o` and `lock_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Write-enable pulse |
| wrdi_i | input | 1 | Write-disable pulse |
| wrsr_i | input | 1 | Status-write pulse |
| prog_i | input | 1 | Page-program pulse |
| sec_erase_i | input | 1 | Sector-erase pulse |
| blk_erase_i | input | 1 | Block-erase pulse |
| chip_erase_i | input | 1 | Chip-erase pulse |
| otp_erase_i | input | 1 | Security-register erase pulse |
| otp_prog_i | input | 1 | Security-register program pulse |
| pd_enter_i | input | 1 | Deep power-down enter pulse |
| pd_exit_i | input | 1 | Deep power-down release pulse |
| addr_i | input | 24 | Target byte address |
| sr_new_i | input | 7 | New status: [4:0] protect code, [6:5] lock bits |
| wp_ni | input | 1 | Active-low write-protect pin |
| wel_o | output | 1 | Write-enable latch |
| prot_o | output | 5 | Current protect code |
| lock_o | output | 2 | Current status-lock bits |
| grant_o | output | 1 | Request in this cycle may proceed |
| dpd_o | output | 1 | Deep power-down active |

## Verification
The assertions assume that the decoder upstream raises at most one command pulse per cycle. They check that assumption on the inputs. The priority between pulses that arrive together is therefore never exercised. The bench drives exactly one pulse, or none, in each cycle, including its random phase. It toggles `wp_ni` and the address freely, because neither has any timing restriction.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  parameter int ADDR_W        = 24;
  parameter int BLK_LSB       = 16;
  parameter int MIN_SPAN_LOG2 = 2;
  parameter int CODE_W        = 5;
  parameter int LOCK_W        = 2;

  localparam int BLK_W = ADDR_W - BLK_LSB;
  localparam int NSPAN = BLK_W - MIN_SPAN_LOG2;

  typedef struct packed {
    logic [LOCK_W-1:0] lock;
    logic [CODE_W-1:0] code;
  } status_t;

  typedef struct packed {
    logic wren;
    logic wrdi;
    logic wrsr;
    logic prog;
    logic sec_erase;
    logic blk_erase;
    logic chip_erase;
    logic otp_erase;
    logic otp_prog;
    logic pd_enter;
    logic pd_exit;
  } cmd_t;
endpackage

// File: rtl/flash_wp_region.sv
module flash_wp_region
  import flash_wp_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic              hit_o,
  output logic              any_o
);
  logic [7:0] top_v, bot_v;

  assign top_v[0] = 1'b0;
  assign bot_v[0] = 1'b0;
  assign top_v[7] = 1'b1;
  assign bot_v[7] = 1'b1;

  // span k covers 2^(MIN_SPAN_LOG2+k-1) blocks at either end
  for (genvar k = 1; k <= 6; k++) begin : g_span
    if (k <= NSPAN) begin : g_on
      localparam int SH = MIN_SPAN_LOG2 + k - 1;
      assign top_v[k] = &blk_i[BLK_W-1:SH];
      assign bot_v[k] = ~|blk_i[BLK_W-1:SH];
    end else begin : g_all
      assign top_v[k] = 1'b1;
      assign bot_v[k] = 1'b1;
    end
  end

  logic [2:0] sel;
  logic       full;
  assign sel   = code_i[2:0];
  assign full  = code_i[4];
  assign hit_o = full | (code_i[3] ? bot_v[sel] : top_v[sel]);
  assign any_o = full | (sel != 3'd0);
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
(
  input  cmd_t cmd_i,
  input  logic wel_i,
  input  logic dpd_i,
  input  logic wp_ni,
  input  logic hit_i,
  input  logic any_i,
  output logic grant_o,
  output logic set_wel_o,
  output logic clr_wel_o,
  output logic load_sr_o,
  output logic pd_set_o,
  output logic pd_clr_o
);
  logic live, arr_ok, chip_ok, otp_ok, sr_ok;

  assign live    = ~dpd_i;
  assign arr_ok  = (cmd_i.prog | cmd_i.sec_erase | cmd_i.blk_erase) & ~hit_i;
  assign chip_ok = cmd_i.chip_erase & ~any_i;
  assign otp_ok  = cmd_i.otp_erase | cmd_i.otp_prog;
  assign sr_ok   = cmd_i.wrsr & wp_ni;

  assign grant_o   = live & wel_i & (arr_ok | chip_ok | otp_ok | sr_ok);
  assign set_wel_o = live & cmd_i.wren;
  assign clr_wel_o = grant_o | (live & cmd_i.wrdi);
  assign load_sr_o = grant_o & cmd_i.wrsr;
  assign pd_set_o  = live & cmd_i.pd_enter;
  assign pd_clr_o  = dpd_i & cmd_i.pd_exit;
endmodule

// File: rtl/flash_wp_regs.sv
module flash_wp_regs
  import flash_wp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    set_wel_i,
  input  logic    clr_wel_i,
  input  logic    load_sr_i,
  input  status_t sr_new_i,
  input  logic    pd_set_i,
  input  logic    pd_clr_i,
  output logic    wel_o,
  output status_t sr_o,
  output logic    dpd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o <= 1'b0;
    end else if (clr_wel_i) begin
      wel_o <= 1'b0;
    end else if (set_wel_i) begin
      wel_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o <= '0;
    end else if (load_sr_i) begin
      sr_o <= sr_new_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpd_o <= 1'b0;
    end else if (pd_set_i) begin
      dpd_o <= 1'b1;
    end else if (pd_clr_i) begin
      dpd_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic              prog_i,
  input  logic              sec_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic              otp_erase_i,
  input  logic              otp_prog_i,
  input  logic              pd_enter_i,
  input  logic              pd_exit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [6:0]        sr_new_i,
  input  logic              wp_ni,
  output logic              wel_o,
  output logic [4:0]        prot_o,
  output logic [1:0]        lock_o,
  output logic              grant_o,
  output logic              dpd_o
);
  cmd_t    cmd;
  status_t sr_q, sr_in;
  logic    hit, any, set_wel, clr_wel, load_sr, pd_set, pd_clr, wel, dpd;

  assign cmd = '{wren: wren_i, wrdi: wrdi_i, wrsr: wrsr_i, prog: prog_i,
                 sec_erase: sec_erase_i, blk_erase: blk_erase_i,
                 chip_erase: chip_erase_i, otp_erase: otp_erase_i,
                 otp_prog: otp_prog_i, pd_enter: pd_enter_i, pd_exit: pd_exit_i};
  assign sr_in = status_t'(sr_new_i);

  flash_wp_region u_region (
    .code_i (sr_q.code),
    .blk_i  (addr_i[ADDR_W-1:BLK_LSB]),
    .hit_o  (hit),
    .any_o  (any)
  );

  flash_wp_gate u_gate (
    .cmd_i     (cmd),
    .wel_i     (wel),
    .dpd_i     (dpd),
    .wp_ni     (wp_ni),
    .hit_i     (hit),
    .any_i     (any),
    .grant_o   (grant_o),
    .set_wel_o (set_wel),
    .clr_wel_o (clr_wel),
    .load_sr_o (load_sr),
    .pd_set_o  (pd_set),
    .pd_clr_o  (pd_clr)
  );

  flash_wp_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_wel_i (set_wel),
    .clr_wel_i (clr_wel),
    .load_sr_i (load_sr),
    .sr_new_i  (sr_in),
    .pd_set_i  (pd_set),
    .pd_clr_i  (pd_clr),
    .wel_o     (wel),
    .sr_o      (sr_q),
    .dpd_o     (dpd)
  );

  assign wel_o  = wel;
  assign dpd_o  = dpd;
  assign prot_o = sr_q.code;
  assign lock_o = sr_q.lock;

  // input assumption: one decoded command per cycle
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd));

  // R2
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !dpd_o) |=> wel_o);

  // R2
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrdi_i && !dpd_o) |=> !wel_o);

  // R3
  grant_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !wel_o);

  // R10
  wp_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> ($stable(prot_o) && $stable(lock_o)));

  // R11
  dpd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dpd_o && !pd_exit_i) |=> (dpd_o && $stable(wel_o) && $stable(prot_o) && $stable(lock_o)));

  // R11
  dpd_nogrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_o |-> !grant_o);

  // R12
  refuse_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((prog_i || sec_erase_i || blk_erase_i || chip_erase_i || wrsr_i) && wel_o && !grant_o)
      |=> (wel_o && $stable(prot_o) && $stable(lock_o)));

  // R4
  top_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_o == 5'b00110 && prog_i && wel_o && !dpd_o) |-> (grant_o == !addr_i[ADDR_W-1]));

  // R6
  full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((prot_o[4] || prot_o[2:0] == 3'b111) && (prog_i || blk_erase_i)) |-> !grant_o);
endmodule

// File: tb/flash_wp_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb;
  localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_WRSR = 3, C_PROG = 4,
                 C_SE = 5, C_BE = 6, C_CE = 7, C_OTPE = 8, C_OTPP = 9,
                 C_PDE = 10, C_PDX = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wren, wrdi, wrsr, prog, se, be, ce, otpe, otpp, pde, pdx;
  logic [23:0] addr;
  logic [6:0] sr_new;
  logic wp_n;
  logic wel, grant, dpd;
  logic [4:0] prot;
  logic [1:0] lock;

  int errors = 0, checks = 0;
  int m_wel = 0, m_dpd = 0, m_code = 0, m_lock = 0;

  always #4 clk = ~clk;

  flash_wp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .prog_i(prog), .sec_erase_i(se), .blk_erase_i(be), .chip_erase_i(ce),
    .otp_erase_i(otpe), .otp_prog_i(otpp), .pd_enter_i(pde), .pd_exit_i(pdx),
    .addr_i(addr), .sr_new_i(sr_new), .wp_ni(wp_n),
    .wel_o(wel), .prot_o(prot), .lock_o(lock), .grant_o(grant), .dpd_o(dpd)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit covered(int code, int unsigned a);
    int n;
    int unsigned size;
    if (code >= 16 || (code % 8) == 7) return 1'b1;
    n = code % 8;
    if (n == 0) return 1'b0;
    size = 32'h40000 << (n - 1);
    if (code >= 8) return a < size;
    return a >= 32'h1000000 - size;
  endfunction

  function automatic int exp_grant(int c, int unsigned a, int w);
    if (m_dpd != 0 || m_wel == 0) return 0;
    case (c)
      C_PROG, C_SE, C_BE: return covered(m_code, a) ? 0 : 1;
      C_CE:               return covered(m_code, 0) || covered(m_code, 24'hFFFFFF) ? 0 : 1;
      C_OTPE, C_OTPP:     return 1;
      C_WRSR:             return w;
      default:            return 0;
    endcase
  endfunction

  // compare registered state, apply one command, compare grant, advance model
  task automatic step(string req, int c, int unsigned a, int nsr, int w);
    int g;
    @(negedge clk);
    check(req, "wel", int'(wel), m_wel);
    check(req, "dpd", int'(dpd), m_dpd);
    check(req, "prot", int'(prot), m_code);
    check(req, "lock", int'(lock), m_lock);
    {wren, wrdi, wrsr, prog, se, be, ce, otpe, otpp, pde, pdx} = '0;
    addr = a[23:0]; sr_new = nsr[6:0]; wp_n = w[0];
    case (c)
      C_WREN: wren = 1'b1;  C_WRDI: wrdi = 1'b1;  C_WRSR: wrsr = 1'b1;
      C_PROG: prog = 1'b1;  C_SE:   se = 1'b1;    C_BE:   be = 1'b1;
      C_CE:   ce = 1'b1;    C_OTPE: otpe = 1'b1;  C_OTPP: otpp = 1'b1;
      C_PDE:  pde = 1'b1;   C_PDX:  pdx = 1'b1;
      default: ;
    endcase
    #1;
    g = exp_grant(c, a, w);
    check(req, "grant", int'(grant), g);
    if (m_dpd != 0) begin
      if (c == C_PDX) m_dpd = 0;
    end else begin
      if (g != 0) begin
        m_wel = 0;
        if (c == C_WRSR) begin m_code = nsr % 32; m_lock = nsr / 32; end
      end else if (c == C_WRDI) m_wel = 0;
      else if (c == C_WREN) m_wel = 1;
      if (c == C_PDE) m_dpd = 1;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {wren, wrdi, wrsr, prog, se, be, ce, otpe, otpp, pde, pdx} = '0;
    addr = '0; sr_new = '0; wp_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1", C_NONE, 0, 0, 1);
    step("R1", C_PROG, 0, 0, 1);
    step("R2", C_WREN, 0, 0, 1);
    step("R2", C_WRDI, 0, 0, 1);
    step("R2", C_WREN, 0, 0, 1);
    step("R7", C_PROG, 0, 0, 1);
    step("R12", C_PROG, 0, 0, 1);
    step("R3", C_WREN, 0, 0, 1);
    step("R10", C_WRSR, 0, 7'b00_00001, 1);
    step("R3", C_WREN, 0, 0, 1);
    step("R4", C_SE, 24'hFC0000, 0, 1);
    step("R12", C_BE, 24'hFFFFFF, 0, 1);
    step("R4", C_BE, 24'hFBFFFF, 0, 1);
    step("R8", C_WREN, 0, 0, 1);
    step("R8", C_CE, 0, 0, 1);
    step("R9", C_OTPP, 24'hFC0000, 0, 1);
    step("R9", C_WREN, 0, 0, 1);
    step("R9", C_OTPE, 0, 0, 1);
    step("R10", C_WREN, 0, 0, 1);
    step("R10", C_WRSR, 0, 7'b11_01110, 0);
    step("R10", C_WRSR, 0, 7'b11_01110, 1);
    step("R5", C_WREN, 0, 0, 1);
    step("R5", C_PROG, 24'h7FFFFF, 0, 1);
    step("R5", C_PROG, 24'h800000, 0, 1);
    step("R5", C_WREN, 0, 0, 1);
    step("R5", C_WRSR, 0, 7'b00_01001, 1);
    step("R5", C_WREN, 0, 0, 1);
    step("R5", C_SE, 24'h03FFFF, 0, 1);
    step("R5", C_SE, 24'h040000, 0, 1);
    step("R4", C_WREN, 0, 0, 1);
    step("R4", C_WRSR, 0, 7'b00_01000, 1);
    step("R4", C_WREN, 0, 0, 1);
    step("R8", C_CE, 0, 0, 1);
    step("R6", C_WREN, 0, 0, 1);
    step("R6", C_WRSR, 0, 7'b00_10000, 1);
    step("R6", C_WREN, 0, 0, 1);
    step("R6", C_PROG, 24'h123456, 0, 1);
    step("R6", C_WRSR, 0, 7'b00_00111, 1);
    step("R6", C_WREN, 0, 0, 1);
    step("R6", C_BE, 24'h555555, 0, 1);
    step("R11", C_PDE, 0, 0, 1);
    step("R11", C_WRDI, 0, 0, 1);
    step("R11", C_WRSR, 0, 7'b00_00000, 1);
    step("R11", C_OTPP, 0, 0, 1);
    step("R11", C_PDX, 0, 0, 1);
    step("R11", C_WRSR, 0, 7'b00_00000, 1);
    step("R11", C_WREN, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      int c, nsr;
      int unsigned a;
      c = int'($urandom_range(0, 11));
      a = $urandom & 32'hFFFFFF;
      nsr = int'($urandom_range(0, 127));
      step("R7", c, a, nsr, int'($urandom_range(0, 3) != 0));
    end
    step("R3", C_NONE, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule